// File: doc/BRIEF.md
# Stackable Layer-Configured Banked Memory

This block is a banked single-port memory built to work either alone or stacked. The base layer always holds bank 0, a complete memory that serves every access when nothing else is fitted. Up to three further layers, numbered 1 to 3, can each add one bank of identical depth and width. This raises the total capacity without changing the design.

At start-up, while a configuration-enable input is high, each layer reports through a small load port whether it is fitted. The block turns this record into a bank mode: one, two or four banks. The mode decides which address bits above the per-bank index choose the bank. When the enable falls, the record is frozen until the next reset. After that the block behaves as a plain memory with a one-cycle read.

Top module: `stack_sram`

## Requirements
- R1: After reset `rdata` is zero, `cfg_err` is low and only layer 0 counts as fitted, so the block runs in one-bank mode.
- R2: A layer record is updated only when `cfg_wr` is high, `cfg_en` is high and the record is not yet locked. The record locks on the first cycle where `cfg_en` is low after having been high. It stays locked, even if `cfg_en` rises again, until reset.
- R3: The bank mode comes from the fitted layers counted upward from layer 0. Layers 1, 2 and 3 fitted gives four banks. Layer 1 fitted without all of 2 and 3 gives two banks. Layer 1 absent gives one bank.
- R4: `cfg_err` is high whenever the fitted pattern of layers 1..3 is anything other than none, {1} or {1,2,3}. The mode is then reduced as stated in R3.
- R5: In one-bank mode both bank-select address bits (`addr[IDX_W+1:IDX_W]`) are ignored, and every access reaches bank 0.
- R6: In two-bank mode `addr[IDX_W]` is the bank number and `addr[IDX_W+1]` is ignored.
- R7: In four-bank mode `addr[IDX_W+1:IDX_W]` is the bank number, with 0 meaning bank 0.
- R8: A read (`acc_en`=1, `wr_en`=0) presents its data on `rdata` after the next rising clock edge. `rdata` then holds until the next read, and writes do not change it.
- R9: A write (`acc_en`=1, `wr_en`=1) changes only the addressed word of the selected bank.
- R10: A bank outside the current mode never receives an enable, and its data never appears on `rdata`.
- R11: Layer 0 is always fitted; a record write that reports layer 0 as absent has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration window open |
| cfg_wr | input | 1 | Strobe to load one layer record |
| cfg_lid | input | 2 | Layer number of the record |
| cfg_present | input | 1 | Layer fitted flag for the record |
| cfg_err | output | 1 | Fitted pattern was not a legal bank count |
| acc_en | input | 1 | Access request |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | IDX_W+2 | Word index in low bits, bank select above |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one cycle after a read |

## Verification
The assertions assume that layer records are loaded only in the configuration window before any access. They also assume that the hold check on `rdata` applies only once the record is locked, because a reconfiguration could otherwise change which banks count as active. The stimulus follows this order in every scenario: reset, open the window, load records, close the window, and only then access the memory. Every read goes to a word that the same scenario wrote first, so no check depends on power-up contents.

// File: rtl/stack_sram_pkg.sv
package stack_sram_pkg;
  localparam int LAYERS = 4;
  localparam int LID_W  = $clog2(LAYERS);

  typedef enum logic [1:0] {
    BK_ONE  = 2'd0,
    BK_TWO  = 2'd1,
    BK_FOUR = 2'd2
  } bank_mode_e;
endpackage

// File: rtl/stack_cfg.sv
module stack_cfg
  import stack_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_wr,
  input  logic [LID_W-1:0] cfg_lid,
  input  logic             cfg_present,
  output bank_mode_e       mode_o,
  output logic             err_o,
  output logic             locked_o
);
  logic [LAYERS-1:1] fit_q, fit_d;
  logic              locked_q, locked_d;
  logic              en_q;

  always_comb begin
    fit_d    = fit_q;
    locked_d = locked_q | (en_q & ~cfg_en);
    if (cfg_wr && cfg_en && !locked_q && (cfg_lid != '0))
      fit_d[cfg_lid] = cfg_present;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fit_q    <= '0;
      locked_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      fit_q    <= fit_d;
      locked_q <= locked_d;
      en_q     <= cfg_en;
    end
  end

  always_comb begin
    if (&fit_q)        mode_o = BK_FOUR;
    else if (fit_q[1]) mode_o = BK_TWO;
    else               mode_o = BK_ONE;
    err_o = !((fit_q == 3'b000) || (fit_q == 3'b001) || (fit_q == 3'b111));
  end

  assign locked_o = locked_q;

  p_locked_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(fit_q));
  p_err_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (mode_o != BK_FOUR));
endmodule

// File: rtl/stack_dec.sv
module stack_dec
  import stack_sram_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int ADDR_W = IDX_W + LID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  bank_mode_e        mode,
  output logic [LAYERS-1:0] bank_en,
  output logic [LAYERS-1:0] bank_we,
  output logic [LID_W-1:0]  bidx,
  output logic [LAYERS-1:0] active
);
  always_comb begin
    case (mode)
      BK_FOUR: begin bidx = addr[ADDR_W-1:IDX_W];        active = 4'b1111; end
      BK_TWO:  begin bidx = {1'b0, addr[IDX_W]};         active = 4'b0011; end
      default: begin bidx = '0;                          active = 4'b0001; end
    endcase
    bank_en = '0;
    if (acc_en) bank_en[bidx] = 1'b1;
    bank_we = bank_en & {LAYERS{wr_en}};
  end

  p_onehot_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en));
  p_inactive_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en & ~active) == '0);
  p_single_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BK_ONE && acc_en) |-> (bank_en == 4'b0001));
endmodule

// File: rtl/stack_bank.sv
module stack_bank #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en && we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (en && !we)  rdata_q <= mem[idx];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/stack_sram.sv
module stack_sram
  import stack_sram_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4,
  localparam int ADDR_W = IDX_W + LID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_lid,
  input  logic              cfg_present,
  output logic              cfg_err,
  input  logic              acc_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rst_s1 <= 1'b0; rst_s2 <= 1'b0; end
    else        begin rst_s1 <= 1'b1; rst_s2 <= rst_s1; end
  end
  logic srst_n;
  assign srst_n = rst_s2;

  bank_mode_e        mode;
  logic              locked;
  logic [LAYERS-1:0] bank_en, bank_we, active;
  logic [LID_W-1:0]  bidx, sel_q, sel_d;
  logic [DATA_W-1:0] bank_rd [LAYERS];

  stack_cfg u_cfg (
    .clk(clk), .rst_n(srst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
    .cfg_lid(cfg_lid), .cfg_present(cfg_present),
    .mode_o(mode), .err_o(cfg_err), .locked_o(locked)
  );

  stack_dec #(.IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(srst_n), .acc_en(acc_en), .wr_en(wr_en), .addr(addr),
    .mode(mode), .bank_en(bank_en), .bank_we(bank_we), .bidx(bidx),
    .active(active)
  );

  for (genvar g = 0; g < LAYERS; g++) begin : g_bank
    stack_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(srst_n), .en(bank_en[g]), .we(bank_we[g]),
      .idx(addr[IDX_W-1:0]), .wdata(wdata), .rdata(bank_rd[g])
    );
  end

  logic rd_issue;
  assign rd_issue = acc_en & ~wr_en;

  always_comb begin
    sel_d = sel_q;
    if (rd_issue) sel_d = bidx;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sel_q <= '0;
    else         sel_q <= sel_d;
  end

  assign rdata = active[sel_q] ? bank_rd[sel_q] : '0;

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (locked && !rd_issue) |=> $stable(rdata));
  p_sel_active_r10: assert property (@(posedge clk) disable iff (!srst_n)
    rd_issue |=> active[sel_q]);
endmodule

// File: tb/stack_sram_tb.sv
module stack_sram_tb_top;
  localparam int DW = 16;
  localparam int IW = 4;
  localparam int AW = IW + 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_en, cfg_wr, cfg_present, cfg_err;
  logic [1:0] cfg_lid;
  logic acc_en, wr_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  stack_sram #(.DATA_W(DW), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
    .cfg_lid(cfg_lid), .cfg_present(cfg_present), .cfg_err(cfg_err),
    .acc_en(acc_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_en = 0; cfg_wr = 0; cfg_lid = 0; cfg_present = 0;
    acc_en = 0; wr_en = 0; addr = 0; wdata = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_load(input logic [1:0] lid, input logic p);
    cfg_lid = lid; cfg_present = p; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_open();
    cfg_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_close();
    cfg_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic mem_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    acc_en = 1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    acc_en = 0; wr_en = 0;
  endtask

  task automatic mem_rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    acc_en = 1; wr_en = 0; addr = a;
    @(negedge clk);
    acc_en = 0;
    chk(req, rdata, exp);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rdata", rdata, '0);
    chk("R1 cfg_err", {15'b0, cfg_err}, 16'h0);
  endtask

  task automatic t_single();
    do_reset();
    cfg_open();
    cfg_load(2'd0, 1'b0); // R11: layer 0 cannot be removed
    cfg_close();
    mem_wr(6'h05, 16'h1111);
    mem_wr(6'h15, 16'h2222);
    mem_rd("R5 alias bit4", 6'h05, 16'h2222);
    mem_rd("R5 alias bit5", 6'h35, 16'h2222);
    mem_rd("R11 base bank alive", 6'h25, 16'h2222);
    chk("R4 no err single", {15'b0, cfg_err}, 16'h0);
  endtask

  task automatic t_two();
    do_reset();
    cfg_open();
    cfg_load(2'd1, 1'b1);
    cfg_close();
    chk("R3 two legal", {15'b0, cfg_err}, 16'h0);
    mem_wr(6'h03, 16'hAAAA);
    mem_wr(6'h13, 16'hBBBB);
    mem_rd("R9 bank0 kept", 6'h03, 16'hAAAA);
    mem_rd("R6 bank1", 6'h13, 16'hBBBB);
    mem_rd("R6 bit5 ignored b0", 6'h23, 16'hAAAA);
    mem_rd("R6 bit5 ignored b1", 6'h33, 16'hBBBB);
  endtask

  task automatic t_four();
    do_reset();
    cfg_open();
    cfg_load(2'd1, 1'b1);
    cfg_load(2'd2, 1'b1);
    cfg_load(2'd3, 1'b1);
    cfg_close();
    chk("R3 four legal", {15'b0, cfg_err}, 16'h0);
    for (int b = 0; b < 4; b++) mem_wr(6'(b * 16 + 7), 16'(16'hC000 + b));
    for (int b = 0; b < 4; b++) mem_rd("R7 R9 bank data", 6'(b * 16 + 7), 16'(16'hC000 + b));
  endtask

  task automatic t_bad();
    do_reset();
    cfg_open();
    cfg_load(2'd1, 1'b1);
    cfg_load(2'd2, 1'b1);
    cfg_close();
    chk("R4 err three", {15'b0, cfg_err}, 16'h1);
    mem_wr(6'h02, 16'h0D0D);
    mem_wr(6'h22, 16'h0E0E); // bank 2 out of mode: reaches bank 0
    mem_rd("R10 bank2 unused", 6'h02, 16'h0E0E);
    do_reset();
    cfg_open();
    cfg_load(2'd2, 1'b1);
    cfg_close();
    chk("R4 err gap", {15'b0, cfg_err}, 16'h1);
    mem_wr(6'h10, 16'h5A5A);
    mem_rd("R4 gap one bank", 6'h00, 16'h5A5A);
  endtask

  task automatic t_lock();
    do_reset();
    cfg_open();
    cfg_close();
    cfg_load(2'd1, 1'b1); // window closed
    cfg_open();
    cfg_load(2'd1, 1'b1); // reopened but locked
    cfg_close();
    mem_wr(6'h01, 16'h7777);
    mem_wr(6'h11, 16'h8888);
    mem_rd("R2 locked one bank", 6'h01, 16'h8888);
  endtask

  task automatic t_hold();
    do_reset();
    cfg_open();
    cfg_load(2'd1, 1'b1);
    cfg_close();
    mem_wr(6'h04, 16'h1234);
    mem_rd("R8 read", 6'h04, 16'h1234);
    mem_wr(6'h04, 16'h4321);
    chk("R8 hold after write", rdata, 16'h1234);
    @(negedge clk);
    chk("R8 hold idle", rdata, 16'h1234);
    mem_rd("R8 new data", 6'h04, 16'h4321);
  endtask

  initial begin
    t_reset();
    t_single();
    t_two();
    t_four();
    t_bad();
    t_lock();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule